// File: doc/BRIEF.md
# Windowed Local Memory Access Bridge

This block lets a 32-bit host register bus reach a 512 KB on-card SRAM that is far larger than the host's register space. The host picks a 2 KB page by writing a window base register. Word accesses that then land in the upper half of the 4 KB register space are steered to the SRAM. The SRAM word address joins the page bits of the base to the offset inside the aperture. A second register, the window data port, reaches the single word that the base points at.

The bridge never moves the base by itself. A host walking across a page edge writes a new base before it continues. Clearing a region is done the same way as any other transfer: the host writes zero words through the aperture. Each host request is acknowledged by a one-cycle ready pulse on the cycle after it is presented. For a read, the data is valid on that same cycle.

Top module: `wlm_bridge`

## Requirements
- R1: While reset is held and on the first cycle after it, hst_ready is low, hst_rdata is zero, mem_en is low and the window base reads back as zero.
- R2: An aligned write to host offset 0x068 loads all 32 bits of the window base. A read of 0x068 returns exactly the value last written, including the bits that addressing ignores.
- R3: An aligned access at host offset 0x800 to 0xFFF drives mem_en in the same cycle. mem_addr, a word address, is then (base bits 18..11) shifted up 9 places, plus offset bits 10..2. Base bits 10..0 have no effect on the address.
- R4: An aligned access at host offset 0x06C reaches the SRAM word at base bits 18..2.
- R5: Every request (hst_sel high for one cycle) is answered by hst_ready high on exactly the next cycle, and there is no ready without a request. A read answer carries the SRAM word returned one cycle after mem_en. A write answer carries zero.
- R6: A request whose offset bits 1..0 are not both zero is acknowledged, but on a write it changes neither the SRAM nor the base. On a read it returns zero.
- R7: Base bits 31..19 never reach mem_addr, so local addresses wrap modulo the 512 KB bank.
- R8: Aperture and data-port accesses never change the window base. The base changes only on an aligned write to 0x068.
- R9: An aligned access to any other offset below 0x800 leaves the SRAM and the base untouched and reads as zero.
- R10: mem_we is high only with mem_en during a host write. In that cycle mem_wdata equals hst_wdata, and each request makes at most one SRAM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 1 | Host request valid for this cycle |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 12 | Host byte offset in register space |
| hst_wdata | input | 32 | Host write word |
| hst_ready | output | 1 | One-cycle acknowledge, the cycle after a request |
| hst_rdata | output | 32 | Read word, valid with hst_ready |
| mem_en | output | 1 | SRAM access strobe |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | 17 | SRAM word address |
| mem_wdata | output | 32 | SRAM write word |
| mem_rdata | input | 32 | SRAM read word, one cycle after mem_en |

## Verification
The following rules are checked on every cycle: the request-to-ready pairing, the lack of any SRAM write for misaligned offsets, the aperture offset bits carried into mem_addr, and the rule that the base holds unless an aligned write hits it. Other behaviour needs data to travel through the SRAM, so only the bench scenarios can show it. That covers page selection by the upper base bits, wrap-around of high base bits, the data port landing on the same word as an aperture access, zero-fill, and a base write followed in the next cycle by an aperture read.

// File: rtl/wlm_pkg.sv
`timescale 1ns/1ps
package wlm_pkg;
  localparam int WORD_W   = 32;
  localparam int LANE_LG2 = 2;

  typedef enum logic [2:0] {
    KIND_IDLE,
    KIND_BASE,
    KIND_DATA,
    KIND_APER,
    KIND_VOID
  } acc_kind_t;

  // all-ones in the low lg2 bits
  function automatic logic [WORD_W-1:0] span_mask(input int lg2);
    if (lg2 >= WORD_W) return '1;
    return (WORD_W'(1) << lg2) - WORD_W'(1);
  endfunction

  // byte address reached through the aperture: page bits of base, offset bits of host
  function automatic logic [WORD_W-1:0] aper_byte_addr(input logic [WORD_W-1:0] base,
                                                       input logic [WORD_W-1:0] off,
                                                       input int win_lg2,
                                                       input int bank_lg2);
    logic [WORD_W-1:0] wm;
    wm = span_mask(win_lg2);
    return ((base & ~wm) | (off & wm)) & span_mask(bank_lg2);
  endfunction

  // byte address reached through the data port: the base itself, folded into the bank
  function automatic logic [WORD_W-1:0] port_byte_addr(input logic [WORD_W-1:0] base,
                                                       input int bank_lg2);
    return base & span_mask(bank_lg2);
  endfunction

  function automatic logic lane_misaligned(input logic [WORD_W-1:0] off);
    return |off[LANE_LG2-1:0];
  endfunction
endpackage

// File: rtl/wlm_decode.sv
`timescale 1ns/1ps
module wlm_decode
  import wlm_pkg::*;
#(
  parameter int HOST_AW    = 12,
  parameter int WIN_LG2    = 11,
  parameter int WIN_OFFSET = 'h800,
  parameter int BASE_OFF   = 'h068,
  parameter int DATA_OFF   = 'h06C
) (
  input  logic               hst_sel,
  input  logic [HOST_AW-1:0] hst_addr,
  output acc_kind_t          kind,
  output logic               misaligned,
  output logic               in_aperture
);
  logic [WORD_W-1:0] off_ext;

  assign off_ext     = WORD_W'(hst_addr);
  assign misaligned  = lane_misaligned(off_ext);
  assign in_aperture = (off_ext >> WIN_LG2) == (WORD_W'(WIN_OFFSET) >> WIN_LG2);

  always_comb begin
    if (!hst_sel)                                kind = KIND_IDLE;
    else if (misaligned)                         kind = KIND_VOID;
    else if (in_aperture)                        kind = KIND_APER;
    else if (off_ext == WORD_W'(BASE_OFF))       kind = KIND_BASE;
    else if (off_ext == WORD_W'(DATA_OFF))       kind = KIND_DATA;
    else                                         kind = KIND_VOID;
  end
endmodule

// File: rtl/wlm_base_reg.sv
`timescale 1ns/1ps
module wlm_base_reg
  import wlm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] base_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= wdata;
  end

  // R2
  base_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> base_q == $past(wdata));
endmodule

// File: rtl/wlm_addr_form.sv
`timescale 1ns/1ps
module wlm_addr_form
  import wlm_pkg::*;
#(
  parameter int HOST_AW  = 12,
  parameter int BANK_LG2 = 19,
  parameter int WIN_LG2  = 11,
  localparam int MEM_AW  = BANK_LG2 - LANE_LG2
) (
  input  acc_kind_t          kind,
  input  logic               hst_wr,
  input  logic [HOST_AW-1:0] hst_addr,
  input  logic [WORD_W-1:0]  hst_wdata,
  input  logic [WORD_W-1:0]  base_q,
  output logic               mem_en,
  output logic               mem_we,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [WORD_W-1:0]  mem_wdata
);
  logic [MEM_AW-1:0] aper_word;
  logic [MEM_AW-1:0] port_word;
  logic [WORD_W-1:0] port_byte;

  generate
    if (WIN_LG2 >= BANK_LG2) begin : g_flat
      // aperture spans the whole bank: base plays no part in the aperture address
      logic [WORD_W-1:0] off_byte;
      assign off_byte  = WORD_W'(hst_addr) & span_mask(BANK_LG2);
      assign aper_word = off_byte[BANK_LG2-1:LANE_LG2];
    end else begin : g_paged
      logic [WORD_W-1:0] aper_byte;
      assign aper_byte = aper_byte_addr(base_q, WORD_W'(hst_addr), WIN_LG2, BANK_LG2);
      assign aper_word = aper_byte[BANK_LG2-1:LANE_LG2];
    end
  endgenerate

  assign port_byte = port_byte_addr(base_q, BANK_LG2);
  assign port_word = port_byte[BANK_LG2-1:LANE_LG2];

  always_comb begin
    mem_en   = (kind == KIND_APER) || (kind == KIND_DATA);
    mem_we   = mem_en && hst_wr;
    mem_addr = (kind == KIND_DATA) ? port_word : aper_word;
  end
  assign mem_wdata = hst_wdata;
endmodule

// File: rtl/wlm_resp.sv
`timescale 1ns/1ps
module wlm_resp
  import wlm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_t         kind,
  input  logic              hst_wr,
  input  logic [WORD_W-1:0] base_q,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              hst_ready,
  output logic [WORD_W-1:0] hst_rdata
);
  logic              memrd_q;
  logic [WORD_W-1:0] hold_q;
  logic              base_rd;
  logic              mem_rd;

  assign base_rd = (kind == KIND_BASE) && !hst_wr;
  assign mem_rd  = ((kind == KIND_APER) || (kind == KIND_DATA)) && !hst_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hst_ready <= 1'b0;
      memrd_q   <= 1'b0;
      hold_q    <= '0;
    end else begin
      hst_ready <= (kind != KIND_IDLE);
      memrd_q   <= mem_rd;
      hold_q    <= base_rd ? base_q : '0;
    end
  end

  assign hst_rdata = memrd_q ? mem_rdata : hold_q;

  // R5
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hst_ready |-> hst_rdata == '0);
endmodule

// File: rtl/wlm_bridge.sv
`timescale 1ns/1ps
module wlm_bridge
  import wlm_pkg::*;
#(
  parameter int HOST_AW    = 12,
  parameter int BANK_LG2   = 19,
  parameter int WIN_LG2    = 11,
  parameter int WIN_OFFSET = 'h800,
  parameter int BASE_OFF   = 'h068,
  parameter int DATA_OFF   = 'h06C,
  localparam int MEM_AW    = BANK_LG2 - LANE_LG2,
  localparam int WIN_WORDS_LG2 = WIN_LG2 - LANE_LG2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hst_sel,
  input  logic               hst_wr,
  input  logic [HOST_AW-1:0] hst_addr,
  input  logic [WORD_W-1:0]  hst_wdata,
  output logic               hst_ready,
  output logic [WORD_W-1:0]  hst_rdata,
  output logic               mem_en,
  output logic               mem_we,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic [WORD_W-1:0]  mem_rdata
);
  acc_kind_t         kind;
  logic              misaligned;
  logic              in_aperture;
  logic              base_load;
  logic [WORD_W-1:0] base_q;

  wlm_decode #(
    .HOST_AW(HOST_AW), .WIN_LG2(WIN_LG2), .WIN_OFFSET(WIN_OFFSET),
    .BASE_OFF(BASE_OFF), .DATA_OFF(DATA_OFF)
  ) u_decode (
    .hst_sel(hst_sel), .hst_addr(hst_addr), .kind(kind),
    .misaligned(misaligned), .in_aperture(in_aperture)
  );

  assign base_load = (kind == KIND_BASE) && hst_wr;

  wlm_base_reg u_base (
    .clk(clk), .rst_n(rst_n), .load(base_load), .wdata(hst_wdata), .base_q(base_q)
  );

  wlm_addr_form #(
    .HOST_AW(HOST_AW), .BANK_LG2(BANK_LG2), .WIN_LG2(WIN_LG2)
  ) u_addr (
    .kind(kind), .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .base_q(base_q), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  wlm_resp u_resp (
    .clk(clk), .rst_n(rst_n), .kind(kind), .hst_wr(hst_wr), .base_q(base_q),
    .mem_rdata(mem_rdata), .hst_ready(hst_ready), .hst_rdata(hst_rdata)
  );

  // R5
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_sel |=> hst_ready);

  // R5
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hst_sel |=> !hst_ready);

  // R6
  misalign_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_sel && hst_addr[LANE_LG2-1:0] != '0) |-> !mem_en);

  // R6
  misalign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_sel && !hst_wr && hst_addr[LANE_LG2-1:0] != '0) |=> hst_rdata == '0);

  // R3
  aper_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && in_aperture) |->
      mem_addr[WIN_WORDS_LG2-1:0] == hst_addr[WIN_LG2-1:LANE_LG2]);

  // R8
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hst_sel && hst_wr && hst_addr == HOST_AW'(BASE_OFF)) |=> $stable(base_q));

  // R10
  memwe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && hst_sel && hst_wr && mem_wdata == hst_wdata));
endmodule

// File: tb/wlm_bridge_test.sv
`timescale 1ns/1ps
module wlm_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hst_sel, hst_wr;
  logic [11:0] hst_addr;
  logic [31:0] hst_wdata;
  logic        hst_ready;
  logic [31:0] hst_rdata;
  logic        mem_en, mem_we;
  logic [16:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  wlm_bridge uut (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_ready(hst_ready),
    .hst_rdata(hst_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // behavioural SRAM: synchronous, one-cycle read
  logic [31:0] sram [int];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) sram[int'(mem_addr)] = mem_wdata;
      else        mem_rdata <= sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 32'h0;
    end
  end

  // reference model state
  logic [31:0] ref_base;
  logic [31:0] ref_mem [int];
  bit          pend_rdy;
  logic [31:0] pend_data;
  string       pend_tag;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_peek(input int w);
    return ref_mem.exists(w) ? ref_mem[w] : 32'h0;
  endfunction

  // one clock: judge last request's answer, then present (or withhold) a new one
  task automatic cycle(input bit s, input bit w, input logic [11:0] a,
                       input logic [31:0] d, input string tag);
    bit exp_en;
    int word;
    logic [31:0] rd;
    int off;
    check(hst_ready == pend_rdy, pend_tag, "ready", 32'(hst_ready), 32'(pend_rdy));
    if (pend_rdy) check(hst_rdata == pend_data, pend_tag, "rdata", hst_rdata, pend_data);

    off    = int'(a);
    exp_en = 0;
    word   = 0;
    rd     = 32'h0;
    if (s && (off % 4) == 0) begin
      if (off >= 2048) begin
        exp_en = 1;
        word = int'((ref_base / 2048) % 256) * 512 + (off % 2048) / 4;
      end else if (off == 104) begin
        if (!w) rd = ref_base;
      end else if (off == 108) begin
        exp_en = 1;
        word = int'(ref_base % 524288) / 4;
      end
    end
    if (exp_en && !w) rd = mem_peek(word);

    hst_sel = s; hst_wr = w; hst_addr = a; hst_wdata = d;
    #1;
    check(mem_en == exp_en, tag, "mem_en", 32'(mem_en), 32'(exp_en));
    if (exp_en) begin
      check(int'(mem_addr) == word, tag, "mem_addr", 32'(mem_addr), 32'(word));
      check(mem_we == w, tag, "mem_we", 32'(mem_we), 32'(w));
      if (w) check(mem_wdata == d, tag, "mem_wdata", mem_wdata, d);
    end

    // model update
    if (s && w && off == 104) ref_base = d;
    if (exp_en && w) ref_mem[word] = d;
    pend_rdy  = s;
    pend_data = (s && !w) ? rd : 32'h0;
    pend_tag  = tag;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cycle(1, 1, a, d, tag);
  endtask
  task automatic rd(input logic [11:0] a, input string tag);
    cycle(1, 0, a, 32'h0, tag);
  endtask
  task automatic idle(input string tag);
    cycle(0, 0, 12'h0, 32'h0, tag);
  endtask

  initial begin
    rst_n = 0; hst_sel = 0; hst_wr = 0; hst_addr = '0; hst_wdata = '0;
    mem_rdata = '0;
    ref_base = '0; pend_rdy = 0; pend_data = '0; pend_tag = "R1";
    repeat (3) @(negedge clk);
    check(hst_ready == 1'b0, "R1", "ready in reset", 32'(hst_ready), 0);
    check(hst_rdata == 32'h0, "R1", "rdata in reset", hst_rdata, 0);
    check(mem_en == 1'b0, "R1", "mem_en in reset", 32'(mem_en), 0);
    rst_n = 1;
    idle("R1");
    rd(12'h068, "R1");                  // base reads zero after reset

    // R2: full readback including ignored low bits
    wr(12'h068, 32'h1234_5FFF, "R2");
    rd(12'h068, "R2");
    idle("R2");

    // R3: aperture on page 3, low base bits ignored
    wr(12'h068, 32'h0000_1FFC, "R3");
    wr(12'h800, 32'hA000_0001, "R3");
    wr(12'hFFC, 32'hA000_0002, "R3");
    wr(12'h904, 32'hA000_0003, "R3");
    rd(12'h800, "R3");
    rd(12'hFFC, "R3");
    rd(12'h904, "R3");
    // R8: other page, same offset, then back: first page unchanged
    wr(12'h068, 32'h0000_2000, "R8");
    wr(12'h800, 32'hB000_0001, "R8");
    rd(12'h068, "R8");                  // base unmoved by aperture traffic
    wr(12'h068, 32'h0000_1800, "R8");
    rd(12'h800, "R8");

    // R4: data port at base word, shares storage with aperture
    wr(12'h068, 32'h0000_1904, "R4");
    rd(12'h06C, "R4");                  // same word as 0x904 on page 3
    wr(12'h06C, 32'hC0DE_0004, "R4");
    wr(12'h068, 32'h0000_1800, "R4");
    rd(12'h904, "R4");

    // R7: high base bits wrap
    wr(12'h068, 32'hFFF8_0800, "R7");
    wr(12'h808, 32'hD000_0007, "R7");
    wr(12'h068, 32'h0000_0800, "R7");
    rd(12'h808, "R7");
    wr(12'h068, 32'h8007_FFFC, "R7");
    wr(12'h06C, 32'hD000_0077, "R7");
    wr(12'h068, 32'h0007_FC00, "R7");
    rd(12'hFFC, "R7");

    // R6: misaligned
    wr(12'h068, 32'h0000_1800, "R6");
    wr(12'h802, 32'hEEEE_EEEE, "R6");
    rd(12'h800, "R6");
    rd(12'h801, "R6");
    wr(12'h06A, 32'h5555_5555, "R6");
    rd(12'h068, "R6");
    rd(12'h06D, "R6");

    // R9: unmapped offsets
    wr(12'h040, 32'h7777_7777, "R9");
    rd(12'h040, "R9");
    rd(12'h068, "R9");
    rd(12'h7FC, "R9");

    // R5: base write then aperture read on the very next cycle, mixed burst, gaps
    wr(12'h068, 32'h0000_2000, "R5");
    rd(12'h800, "R5");
    wr(12'h810, 32'h1111_2222, "R5");
    rd(12'h810, "R5");
    idle("R5");
    rd(12'h810, "R5");
    idle("R5");
    idle("R5");

    // R10: zero-fill a stretch across a page edge, then read back
    wr(12'h068, 32'h0000_1800, "R10");
    for (int i = 0; i < 4; i++) wr(12'hFF0 + 12'(i * 4), 32'h0, "R10");
    wr(12'h068, 32'h0000_2000, "R10");
    for (int i = 0; i < 4; i++) wr(12'h800 + 12'(i * 4), 32'h0, "R10");
    rd(12'h800, "R10");
    rd(12'h810, "R10");
    wr(12'h068, 32'h0000_1800, "R10");
    rd(12'hFFC, "R10");
    rd(12'h904, "R10");
    idle("R10");
    idle("R10");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run hung got %h expected %h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule